// File: doc/BRIEF.md
# Byte/Word Addressable RAM

This block is a small synchronous RAM for a simple 16-bit processor. The processor presents a byte address on a 16-bit bus. On a write it also gives a 16-bit data word and a size select, which picks either a single-byte store or an aligned two-byte store. The store holds 1024 bytes at addresses 0 through 1023. Any address at or above 1024 falls outside the store: a write there is dropped and a read there returns zero.

Internally the store is split into two 8-bit lanes. The even lane holds the bytes at even addresses and the odd lane holds the bytes at odd addresses. One row index addresses both lanes, so a full aligned word is read, or written, in one clock.

A read is registered and takes one cycle. The data for the address presented before a rising edge appears on the output just after that edge. The low byte of the output is the byte at the even address of the pair, and the high byte is the byte at the next address. If a read and a write hit the same location in the same cycle, the read returns the contents from before the write.

Top module: `byte_word_ram`

## Requirements
- R1: The address is a 16-bit byte address. Bytes 0 to 1023 are stored, and address 1023 is readable as the high byte of the pair at 1022.
- R2: When `wr_en`=1 and `wr_word`=0 at an in-range address, `wdata[7:0]` is stored at that exact byte address. The other byte of the pair is left unchanged.
- R3: When `wr_en`=1 and `wr_word`=1 at an in-range even address A, `wdata[7:0]` is stored at A and `wdata[15:8]` is stored at A+1.
- R4: A word write (`wr_word`=1) to an odd address (`addr[0]`=1) is ignored and changes no byte.
- R5: A write to any address of 1024 or above is ignored and changes no byte, including the byte that the low address bits alias to.
- R6: After the rising edge following presentation of an in-range `addr`, `rdata[7:0]` holds the byte at `addr` with bit 0 cleared, and `rdata[15:8]` holds the following byte.
- R7: After the rising edge following presentation of an address of 1024 or above, `rdata` is 0.
- R8: A read in the same cycle as a write to the same pair returns the contents from before the write.
- R9: While `rst_n` is low, `rdata` is 0.
- R10: With `wr_en`=0, no byte changes, whatever `wr_word` and `wdata` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all storage updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the read-output register |
| addr | input | 16 | Byte address for the read and the write |
| wr_en | input | 1 | Write strobe |
| wr_word | input | 1 | 1 = aligned two-byte write, 0 = single-byte write |
| wdata | input | 16 | Write data; only bits 7:0 are used for a byte write |
| rdata | output | 16 | Registered read data of the pair containing the previous address |

## Verification
The hardest case to reach from the ports is a write that is dropped while its low address bits match a real location. This happens for an odd-aligned word write, and for a write at 1024 or above that aliases onto a stored byte. Both look like ordinary writes on the bus. The only evidence of a mistake is a corrupted byte elsewhere, which shows up only on a later read of the pair it aliases to. The stimulus first fills every byte with known data. It then issues directed odd-word and aliased out-of-range writes, each followed by a read of the pair they would have hit. Random traffic adds further such writes, biased toward a high share of bad alignments and out-of-range addresses. The bench's reference model catches any stray store on the next read of that pair.

// File: rtl/bwram_pkg.sv
package bwram_pkg;
    // width of one byte lane and number of lanes per word
    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int WORD_W = LANE_W * LANES;

    typedef logic [LANES-1:0]  lane_mask_t;
    typedef logic [LANE_W-1:0] lane_byte_t;
endpackage

// File: rtl/bwram_decode.sv
module bwram_decode
    import bwram_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int MEM_BYTES = 1024,
    localparam int ROWS     = MEM_BYTES / LANES,
    localparam int ROW_W    = $clog2(ROWS)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              wr_word,
    output lane_mask_t        lane_we,
    output logic              hit,
    output logic [ROW_W-1:0]  row
);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(MEM_BYTES);

    always_comb begin
        hit = ({1'b0, addr} < LIMIT);
        row = addr[ROW_W:1];
    end

    always_comb begin
        lane_we = '0;
        if (wr_en && hit) begin
            if (wr_word) begin
                // only an aligned pair may be written as a word
                if (!addr[0]) begin
                    lane_we = '1;
                end
            end else begin
                lane_we[addr[0]] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/bwram_lane.sv
module bwram_lane
    import bwram_pkg::*;
#(
    parameter int ROWS  = 512,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [ROW_W-1:0] row,
    input  lane_byte_t       wd,
    output lane_byte_t       rd
);
    lane_byte_t store [ROWS];

    // read-before-write: the registered read sees the old contents
    always_ff @(posedge clk) begin
        if (we) begin
            store[row] <= wd;
        end
        rd <= store[row];
    end
endmodule

// File: rtl/byte_word_ram.sv
module byte_word_ram
    import bwram_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int MEM_BYTES = 1024,
    localparam int ROWS     = MEM_BYTES / LANES,
    localparam int ROW_W    = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              wr_word,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    lane_mask_t       lane_we;
    logic             hit;
    logic             hit_q;
    logic [ROW_W-1:0] row;
    lane_byte_t       lane_rd [LANES];

    bwram_decode #(
        .ADDR_W    (ADDR_W),
        .MEM_BYTES (MEM_BYTES)
    ) u_dec (
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_word (wr_word),
        .lane_we (lane_we),
        .hit     (hit),
        .row     (row)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_byte_t wd;
        if (g == 0) begin : g_low
            assign wd = wdata[LANE_W-1:0];
        end else begin : g_high
            // a byte write to an odd address takes the low data byte
            assign wd = wr_word ? wdata[g*LANE_W +: LANE_W] : wdata[LANE_W-1:0];
        end

        bwram_lane #(
            .ROWS (ROWS)
        ) u_lane (
            .clk (clk),
            .we  (lane_we[g]),
            .row (row),
            .wd  (wd),
            .rd  (lane_rd[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
        end else begin
            hit_q <= hit;
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_q) begin
            for (int i = 0; i < LANES; i++) begin
                rdata[i*LANE_W +: LANE_W] = lane_rd[i];
            end
        end
    end
endmodule

// File: rtl/byte_word_ram_chk.sv
module byte_word_ram_chk
    import bwram_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int MEM_BYTES = 1024
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              wr_word,
    input lane_mask_t        lane_we,
    input logic [WORD_W-1:0] rdata
);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(MEM_BYTES);

    // R7
    oor_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, addr} >= LIMIT) |=> (rdata == '0));

    // R4
    odd_word_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_word && addr[0]) |-> (lane_we == '0));

    // R5
    oor_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ({1'b0, addr} >= LIMIT)) |-> (lane_we == '0));

    // R10
    idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> (lane_we == '0));

    // R2
    byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_word && ({1'b0, addr} < LIMIT)) |-> ($countones(lane_we) == 1 && lane_we[addr[0]]));

    // R3
    word_both_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_word && !addr[0] && ({1'b0, addr} < LIMIT)) |-> (lane_we == '1));

    // R9
    always_comb begin
        if (!rst_n) begin
            reset_zero_chk: assert (rdata == '0);
        end
    end
endmodule

bind byte_word_ram byte_word_ram_chk #(
    .ADDR_W    (ADDR_W),
    .MEM_BYTES (MEM_BYTES)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_word (wr_word),
    .lane_we (lane_we),
    .rdata   (rdata)
);

// File: tb/sim_byte_word_ram.sv
module sim_byte_word_ram;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        wr_en = 1'b0;
    logic        wr_word = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] model [1024];

    always #4 clk = ~clk;   // 125 MHz

    byte_word_ram u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_word (wr_word),
        .wdata   (wdata),
        .rdata   (rdata)
    );

    function automatic logic [15:0] exp_read(input logic [15:0] a);
        if (a >= 16'd1024) return 16'h0000;
        return {model[{a[9:1], 1'b1}], model[{a[9:1], 1'b0}]};
    endfunction

    task automatic check(input string tag, input logic [15:0] a, input logic [15:0] exp);
        checks++;
        if (rdata !== exp) begin
            errors++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rdata, exp);
        end
    endtask

    task automatic op(input logic [15:0] a, input logic we, input logic ww,
                      input logic [15:0] d, input string tag, input bit chk);
        logic [15:0] exp;
        @(negedge clk);
        addr = a; wr_en = we; wr_word = ww; wdata = d;
        exp = exp_read(a);                  // read-before-write (R8)
        @(posedge clk);
        #1;
        if (we && a < 16'd1024) begin
            if (ww) begin
                if (!a[0]) begin
                    model[a[9:0]]        = d[7:0];
                    model[a[9:0] + 10'd1] = d[15:8];
                end
            end else begin
                model[a[9:0]] = d[7:0];
            end
        end
        if (chk) check(tag, a, exp);
        wr_en = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd2718);

        // R9: output held at zero during reset
        repeat (3) @(posedge clk);
        #1;
        check("R9", addr, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;

        // fill every byte with known content, unchecked
        for (int i = 0; i < 1024; i += 2) begin
            op(16'(i), 1'b1, 1'b1, 16'((i * 16'h3B1) ^ 16'hA55A), "init", 1'b0);
        end

        // R1: top byte of the store
        op(16'd1022, 1'b0, 1'b0, 16'h0, "R1", 1'b1);
        op(16'd1023, 1'b0, 1'b0, 16'h0, "R1", 1'b1);

        // R2: byte writes to odd and even addresses
        op(16'd301, 1'b1, 1'b0, 16'hC35A, "R2", 1'b0);
        op(16'd300, 1'b0, 1'b0, 16'h0, "R2", 1'b1);
        op(16'd300, 1'b1, 1'b0, 16'h7E11, "R2", 1'b0);
        op(16'd301, 1'b0, 1'b0, 16'h0, "R2", 1'b1);

        // R3: little-endian word write
        op(16'd600, 1'b1, 1'b1, 16'hBEEF, "R3", 1'b0);
        op(16'd601, 1'b0, 1'b0, 16'h0, "R3", 1'b1);

        // R4: odd word write dropped
        op(16'd401, 1'b1, 1'b1, 16'hDEAD, "R4", 1'b0);
        op(16'd400, 1'b0, 1'b0, 16'h0, "R4", 1'b1);
        op(16'd402, 1'b0, 1'b0, 16'h0, "R4", 1'b1);

        // R5: out-of-range writes alias onto real bytes but must not land
        op(16'd1034, 1'b1, 1'b0, 16'h0099, "R5", 1'b0);
        op(16'd10, 1'b0, 1'b0, 16'h0, "R5", 1'b1);
        op(16'hFFFE, 1'b1, 1'b1, 16'h1234, "R5", 1'b0);
        op(16'd1022, 1'b0, 1'b0, 16'h0, "R5", 1'b1);

        // R7: out-of-range reads
        op(16'd1024, 1'b0, 1'b0, 16'h0, "R7", 1'b1);
        op(16'hFFFF, 1'b0, 1'b0, 16'h0, "R7", 1'b1);

        // R10: strobe low
        op(16'd50, 1'b0, 1'b1, 16'hFFFF, "R10", 1'b0);
        op(16'd51, 1'b0, 1'b0, 16'hAAAA, "R10", 1'b1);

        // R8: read during write returns old data, then new data
        op(16'd500, 1'b1, 1'b1, 16'h5AA5, "R8", 1'b1);
        op(16'd500, 1'b0, 1'b0, 16'h0, "R8", 1'b1);

        // R6: random mixed traffic
        for (int n = 0; n < 4000; n++) begin
            logic [15:0] a;
            int unsigned kind;
            kind = $urandom % 10;
            if ($urandom % 6 == 0) a = 16'(16'd1024 + ($urandom % 64512));
            else                   a = 16'($urandom % 1024);
            case (kind)
                0, 1, 2, 3: op(a, 1'b0, 1'($urandom), 16'($urandom), "R6", 1'b1);
                4, 5, 6:    op(a, 1'b1, 1'b0, 16'($urandom), "R6", 1'b1);
                default:    op(a, 1'b1, 1'b1, 16'($urandom), "R6", 1'b1);
            endcase
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule